// File: doc/BRIEF.md
# Single-Line Direction Predictor with Speculative History

This block predicts the direction of conditional branches for a pipeline that looks a branch up in stage 2 and learns its real outcome in stage 5. There is no table indexing by address. Only one predictor line exists, and it holds two four-state predictors. A single history bit records the direction of the most recent branch and picks which of the two predictors answers. One predictor serves branches that follow a taken branch, and the other serves branches that follow a not-taken branch.

A mode input controls how the history bit is maintained. In resolve-only mode, the bit is written only when a branch resolves, with the actual direction. In speculative mode, every accepted prediction writes its own predicted direction into the bit at once. The resolve stage then rewrites the bit with the true direction, but only when the branch was mispredicted. Each lookup remembers which predictor it used and what it guessed, in a small in-order record queue. This lets the resolve stage train the same predictor that made the guess. Pipeline redirection appears only as two kill flags: one for the stage-1 slot and one for all younger work.

Top module: `spec_hist_predictor`

## Requirements
- R1: While reset is asserted (asynchronous, active low), and right after it is released, the history bit reads 1 (taken) and both predictors read 2'b10 (take-wrong).
- R2: A predictor state is 2 bits. Bit 1 is the direction guessed (1 = taken), and bit 0 is 1 for a "right" state and 0 for a "wrong" state: take-wrong 10, take-right 11, not-take-wrong 00, not-take-right 01. `pred_taken` is bit 1 of the predictor that the current history bit selects: `st_after_taken` when the history is 1, and `st_after_not` when it is 0.
- R3: On training, an outcome equal to the guessed direction moves the predictor to the right state of that direction. A wrong outcome takes a right state to the wrong state of the same direction. It takes a wrong state to the wrong state of the opposite direction.
- R4: With `spec_mode` low, a resolve that has an outstanding branch writes the actual direction into the history bit. Predictions leave the history bit unchanged.
- R5: With `spec_mode` high, an accepted prediction writes its predicted direction into the history bit. A resolve changes the history bit only on a mispredict, and then writes the actual direction.
- R6: Each resolve trains the predictor that was selected when that same branch was predicted. Branches resolve in the order they were predicted, and up to DEPTH can be outstanding.
- R7: `mispredict` and `kill_younger` are high in the cycle in which a resolve with an outstanding branch carries a direction different from the one predicted. All outstanding branches are then discarded. A prediction offered in that same cycle is not recorded and does not write the history bit.
- R8: `kill_fetch` is high exactly when a prediction is accepted with a taken guess.
- R9: A resolve with no outstanding branch is ignored: no flag rises, and neither the predictors nor the history bit change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spec_mode | input | 1 | 1: speculative history update, 0: update at resolve only |
| pred_valid | input | 1 | A branch is looked up in stage 2 this cycle |
| pred_taken | output | 1 | Predicted direction for the stage-2 branch |
| kill_fetch | output | 1 | Squash the stage-1 instruction (accepted taken guess) |
| res_valid | input | 1 | The oldest outstanding branch resolves in stage 5 |
| res_taken | input | 1 | Actual direction of the resolving branch |
| mispredict | output | 1 | The resolving branch was mispredicted |
| kill_younger | output | 1 | Squash all instructions younger than the resolving branch |
| hist_taken | output | 1 | Current history bit |
| st_after_taken | output | 2 | State of the predictor used after a taken branch |
| st_after_not | output | 2 | State of the predictor used after a not-taken branch |

## Verification
A stage-5 resolve and a stage-2 lookup can land in the same cycle. The interesting cases are a correct resolve that frees a queue slot while a new branch is recorded, and a mispredict that must win over the lookup and discard it. The bench drives both lookup and resolve high in the same cycle, using random traffic and directed cases in both modes. In the directed cases the resolving direction is forced opposite to its recorded guess. The bench judges the kill flags in that cycle and the history bit and predictor states after the edge, against a reference model that applies the resolve before the lookup.

// File: rtl/spec_hist_predictor.sv
module spec_hist_predictor #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spec_mode,
  input  logic       pred_valid,
  output logic       pred_taken,
  output logic       kill_fetch,
  input  logic       res_valid,
  input  logic       res_taken,
  output logic       mispredict,
  output logic       kill_younger,
  output logic       hist_taken,
  output logic [1:0] st_after_taken,
  output logic [1:0] st_after_not
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] TAKE_WRONG = 2'b10;

  logic             hist_q;
  logic [1:0]       st_t, st_n;
  logic [DEPTH-1:0] q_sel, q_pred;
  logic [PW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    cnt;

  function automatic logic [1:0] train(input logic [1:0] s, input logic act);
    if (act == s[1]) return {s[1], 1'b1};
    else if (s[0])   return {s[1], 1'b0};
    else             return {~s[1], 1'b0};
  endfunction

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire       has_res   = res_valid && (cnt != '0);
  wire       head_sel  = q_sel[rd_ptr];
  wire       head_pred = q_pred[rd_ptr];
  wire [1:0] cur       = hist_q ? st_t : st_n;
  wire       room      = (cnt != CW'(DEPTH)) || has_res;

  assign pred_taken   = cur[1];
  assign mispredict   = has_res && (res_taken != head_pred);
  assign kill_younger = mispredict;

  wire push = pred_valid && !mispredict && room;
  assign kill_fetch = push && pred_taken;

  assign hist_taken     = hist_q;
  assign st_after_taken = st_t;
  assign st_after_not   = st_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 1'b1;
      st_t   <= TAKE_WRONG;
      st_n   <= TAKE_WRONG;
    end else begin
      if (has_res) begin
        if (head_sel) st_t <= train(st_t, res_taken);
        else          st_n <= train(st_n, res_taken);
      end
      if (!spec_mode) begin
        if (has_res) hist_q <= res_taken;
      end else if (mispredict) begin
        hist_q <= res_taken;
      end else if (push) begin
        hist_q <= pred_taken;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_sel  <= '0;
      q_pred <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else if (mispredict) begin
      rd_ptr <= wr_ptr;
      cnt    <= '0;
    end else begin
      if (push) begin
        q_sel[wr_ptr]  <= hist_q;
        q_pred[wr_ptr] <= pred_taken;
        wr_ptr         <= bump(wr_ptr);
      end
      if (has_res) rd_ptr <= bump(rd_ptr);
      if (push && !has_res)      cnt <= cnt + 1'b1;
      else if (!push && has_res) cnt <= cnt - 1'b1;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (hist_q && st_t == TAKE_WRONG && st_n == TAKE_WRONG));

  assert_train_taken_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (has_res && head_sel) |=> (st_t[0] == ($past(res_taken) == $past(st_t[1]))));

  assert_hist_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!spec_mode && !has_res) |=> $stable(hist_q));

  assert_hist_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_mode && push) |=> (hist_q == $past(pred_taken)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |=> (cnt == '0));

  assert_empty_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cnt == '0) |=> ($stable(st_t) && $stable(st_n)));
endmodule

// File: tb/spec_hist_predictor_test.sv
module spec_hist_predictor_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 4;

  logic clk = 1'b0, rst_n = 1'b0, spec_mode = 1'b0;
  logic pred_valid = 1'b0, res_valid = 1'b0, res_taken = 1'b0;
  logic pred_taken, kill_fetch, mispredict, kill_younger, hist_taken;
  logic [1:0] st_after_taken, st_after_not;

  spec_hist_predictor #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .spec_mode(spec_mode),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .kill_fetch(kill_fetch),
    .res_valid(res_valid), .res_taken(res_taken),
    .mispredict(mispredict), .kill_younger(kill_younger),
    .hist_taken(hist_taken), .st_after_taken(st_after_taken), .st_after_not(st_after_not)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, brn = 0;
  bit m_hist, sm;
  bit [1:0] m_t, m_n;
  bit [1:0] mq[$];
  bit act_q[$];

  function automatic bit [1:0] ref_train(input bit [1:0] s, input bit act);
    if (act == s[1]) return {s[1], 1'b1};
    if (s[0]) return {s[1], 1'b0};
    return {~s[1], 1'b0};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input bit mode);
    @(negedge clk);
    rst_n = 1'b0; pred_valid = 1'b0; res_valid = 1'b0; spec_mode = mode; sm = mode;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_hist = 1'b1; m_t = 2'b10; m_n = 2'b10;
    mq.delete(); act_q.delete();
    #1;
    chk("R1 hist", hist_taken, 1);
    chk("R1 after_taken", st_after_taken, 2);
    chk("R1 after_not", st_after_not, 2);
  endtask

  task automatic step(input bit pv, input bit rv, input bit newo);
    bit rt, e_pred, e_has, e_mis, e_push, old_hist;
    @(negedge clk);
    rt = (rv && act_q.size() > 0) ? act_q[0] : 1'($urandom % 2);
    pred_valid = pv; res_valid = rv; res_taken = rt;
    #1;
    e_pred = m_hist ? m_t[1] : m_n[1];
    e_has  = rv && mq.size() > 0;
    e_mis  = e_has && (rt != mq[0][0]);
    e_push = pv && !e_mis && (mq.size() < DEPTH || e_has);
    chk("R2 pred_taken", pred_taken, e_pred);
    chk("R7 mispredict", mispredict, e_mis);
    chk("R7 kill_younger", kill_younger, e_mis);
    chk("R8 kill_fetch", kill_fetch, e_push && e_pred);
    @(posedge clk);
    old_hist = m_hist;
    if (e_has) begin
      if (mq[0][1]) m_t = ref_train(m_t, rt);
      else          m_n = ref_train(m_n, rt);
    end
    if (!sm) begin
      if (e_has) m_hist = rt;
    end else if (e_mis) m_hist = rt;
    else if (e_push) m_hist = e_pred;
    if (e_mis) begin
      mq.delete(); act_q.delete();
    end else begin
      if (e_has) begin void'(mq.pop_front()); void'(act_q.pop_front()); end
      if (e_push) begin mq.push_back({old_hist, e_pred}); act_q.push_back(newo); brn++; end
    end
    #1;
    chk(sm ? "R5 hist" : "R4 hist", hist_taken, m_hist);
    chk("R3/R6 after_taken", st_after_taken, m_t);
    chk("R3/R6 after_not", st_after_not, m_n);
    pred_valid = 1'b0; res_valid = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      // R9: resolve with nothing outstanding
      step(1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b1, 1'b1);
      // R7: lookup and mispredicting resolve in the same cycle
      step(1'b1, 1'b0, 1'b0);
      act_q[0] = ~mq[0][0];
      step(1'b1, 1'b1, 1'b1);
      step(1'b0, 1'b1, 1'b0);
      // R6: fill the record queue to DEPTH, then resolve in order
      for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 1'($urandom % 2));
      step(1'b1, 1'b0, 1'b0);
      for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, 1'b0);
      // R3/R4/R5: loop with one never-taken and one always-taken branch
      brn = 0;
      for (int i = 0; i < 300; i++)
        step(1'($urandom % 3 != 0), 1'($urandom % 2), 1'(brn % 2));
      // random traffic
      for (int i = 0; i < 2000; i++)
        step(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule